// File: doc/BRIEF.md
# Multi-Group Scan Enable Transition Test Sequencer

This block owns a small full-scan cell array, organised as several parallel chains, and the sequencer that runs one two-pattern transition delay test on it. Every scan cell belongs to one of several enable groups, and each group has its own scan enable line. Within a test, the enable of each group stays fixed from just before the launch pulse until just after the capture pulse. The launch value of a held group's cells therefore comes from shifting, as in a skewed-load test, while the cells of the released groups load the response of the surrounding logic, as in a broadside test. None of the enables has to switch at speed.

A test starts with a one-cycle start strobe that also samples the per-group hold mask. The sequencer loads the initial vector with every enable high, waiting a programmable number of settle cycles with the enables at the mask value. It then gives one launch step and one capture step on consecutive cycles. Finally it unloads the response with every enable high again and raises a one-cycle done flag. While a vector is loaded, the previous contents of the chains leave through the scan outputs, so the unload of one test overlaps the load of the next. The logic under test sits outside the block: the cell states go out on `cell_q_o`, and its functional responses come back on `func_d_i`.

Top module: `segscan_seq`

## Requirements
- R1: While reset is asserted and right after it, every scan enable is 1, done is 0, and every cell and scan output is 0.
- R2: A start strobe in the idle state begins a load of exactly CHAIN_LEN cycles with every enable at 1. The bit driven on a chain's scan input in load cycle k (counted from 0) ends in position CHAIN_LEN-1-k. Enables are also 1 while idle and while done.
- R3: After the load, the sequencer spends SETUP_CYCLES cycles with the enables at their test values, and the cells keep their loaded contents throughout.
- R4: The launch step is followed on the very next cycle by the capture step, and no enable changes between the settle cycles, the launch and the capture.
- R5: A cell whose group enable is 1 takes the previous cell of its chain on both the launch and the capture step. Position 0 takes the chain's scan input.
- R6: A cell whose group enable is 0 loads its functional input `func_d_i` on both the launch and the capture step.
- R7: With a hold mask of all zeros, the test is a pure broadside test: both steps load functional data into every cell.
- R8: The hold mask is sampled only on the accepted start strobe. Mask changes and further start strobes before done have no effect on the enables or on the cycle count.
- R9: During a load, each chain's scan output shows the chain's previous contents, last position first, one position per cycle.
- R10: Right after the capture step, CHAIN_LEN unload cycles follow with every enable at 1, and each scan output shows the captured response, last position first. The next cycle raises done for exactly one cycle, and the block then returns to idle.
- R11: Cell c*CHAIN_LEN+p of `cell_q_o` and `func_d_i` is position p of chain c. It belongs to group p mod NUM_GROUPS, and hold mask bit g set to 1 keeps the enable of group g at 1 during the test.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequencer and all scan cells |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle test start strobe, honoured only when idle |
| hold_mask_i | input | NUM_GROUPS | Per-group hold mask; a 1 keeps that group shifting through launch and capture |
| scan_in_i | input | NUM_CHAINS | Serial data into position 0 of each chain |
| func_d_i | input | NUM_CHAINS*CHAIN_LEN | Functional responses from the logic under test, one per cell |
| cell_q_o | output | NUM_CHAINS*CHAIN_LEN | Current state of every scan cell, fed to the logic under test |
| scan_out_o | output | NUM_CHAINS | Last position of each chain |
| scan_en_o | output | NUM_GROUPS | Scan enable of each group |
| done_o | output | 1 | One-cycle pulse at the end of a test |

## Verification
On every cycle, the assertions check that the enables are all high while shifting and hold still across launch and capture. They also check that launch always follows the settle window and is followed at once by capture, that the sampled mask stays frozen for a whole test, that the cells keep their contents while settling, and that one held cell and one released cell take the right source on each step. Only the bench scenarios can show the full captured response. The bench sweeps every hold mask against several vectors through a stand-in logic cloud and checks that the response agrees with a skewed-load, broadside or mixed model. Those scenarios also show the interleaved group mapping, the overlap of unload and load, and that strobes and mask changes in mid-test are ignored.

// File: rtl/segscan_pkg.sv
package segscan_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SHIFT_IN,
      ST_SETUP,
      ST_LAUNCH,
      ST_CAPTURE,
      ST_SHIFT_OUT,
      ST_DONE
   } seq_state_t;

   // Cells are interleaved across groups by chain position.
   function automatic int unsigned group_of(input int unsigned pos, input int unsigned ngroups);
      return pos % ngroups;
   endfunction

   function automatic int unsigned max_of(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/segscan_ctrl.sv
module segscan_ctrl
   import segscan_pkg::*;
#(
   parameter int unsigned NUM_GROUPS    = 3,
   parameter int unsigned CHAIN_LEN     = 4,
   parameter int unsigned SETUP_CYCLES  = 2,
   parameter bit          EN_REGISTERED = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [NUM_GROUPS-1:0] hold_mask_i,
   output seq_state_t            state_o,
   output logic                  step_o,
   output logic [NUM_GROUPS-1:0] scan_en_o,
   output logic [NUM_GROUPS-1:0] hold_q_o,
   output logic                  done_o
);

   localparam int unsigned CNT_MAX = max_of(CHAIN_LEN, SETUP_CYCLES);
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] LAST_SHIFT = CNT_W'(CHAIN_LEN - 1);
   localparam logic [CNT_W-1:0] LAST_SETUP = CNT_W'(SETUP_CYCLES - 1);

   seq_state_t            state_q, state_d;
   logic [CNT_W-1:0]      cnt_q, cnt_d;
   logic [NUM_GROUPS-1:0] hold_q, hold_d;

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      hold_d  = hold_q;
      unique case (state_q)
         ST_IDLE: begin
            if (start_i) begin
               state_d = ST_SHIFT_IN;
               cnt_d   = '0;
               hold_d  = hold_mask_i;
            end
         end
         ST_SHIFT_IN: begin
            if (cnt_q == LAST_SHIFT) begin
               state_d = ST_SETUP;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_SETUP: begin
            if (cnt_q == LAST_SETUP) begin
               state_d = ST_LAUNCH;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_LAUNCH:  state_d = ST_CAPTURE;
         ST_CAPTURE: begin
            state_d = ST_SHIFT_OUT;
            cnt_d   = '0;
         end
         ST_SHIFT_OUT: begin
            if (cnt_q == LAST_SHIFT) begin
               state_d = ST_DONE;
               cnt_d   = '0;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
         end
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         hold_q  <= '0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         hold_q  <= hold_d;
      end
   end

   function automatic logic [NUM_GROUPS-1:0] en_for(input seq_state_t st,
                                                    input logic [NUM_GROUPS-1:0] hm);
      if (st == ST_SETUP || st == ST_LAUNCH || st == ST_CAPTURE) return hm;
      return '1;
   endfunction

   generate
      if (EN_REGISTERED) begin : g_en_reg
         logic [NUM_GROUPS-1:0] en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) en_q <= '1;
            else        en_q <= en_for(state_d, hold_d);
         end
         assign scan_en_o = en_q;
      end else begin : g_en_comb
         assign scan_en_o = en_for(state_q, hold_q);
      end
   endgenerate

   assign state_o  = state_q;
   assign hold_q_o = hold_q;
   assign done_o   = (state_q == ST_DONE);
   assign step_o   = (state_q == ST_SHIFT_IN) || (state_q == ST_LAUNCH) ||
                     (state_q == ST_CAPTURE)  || (state_q == ST_SHIFT_OUT);

endmodule

// File: rtl/segscan_cells.sv
module segscan_cells
   import segscan_pkg::*;
#(
   parameter int unsigned NUM_CHAINS = 2,
   parameter int unsigned CHAIN_LEN  = 4,
   parameter int unsigned NUM_GROUPS = 3,
   localparam int unsigned CELLS     = NUM_CHAINS * CHAIN_LEN
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  step_i,
   input  logic [NUM_GROUPS-1:0] grp_en_i,
   input  logic [NUM_CHAINS-1:0] scan_in_i,
   input  logic [CELLS-1:0]      func_d_i,
   output logic [CELLS-1:0]      cell_q_o,
   output logic [NUM_CHAINS-1:0] scan_out_o
);

   generate
      for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
         for (genvar p = 0; p < CHAIN_LEN; p++) begin : g_cell
            localparam int unsigned IDX = c * CHAIN_LEN + p;
            localparam int unsigned GRP = group_of(p, NUM_GROUPS);
            logic prev;
            logic cell_r;

            if (p == 0) begin : g_head
               assign prev = scan_in_i[c];
            end else begin : g_body
               assign prev = cell_q_o[IDX-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)      cell_r <= 1'b0;
               else if (step_i) cell_r <= grp_en_i[GRP] ? prev : func_d_i[IDX];
            end

            assign cell_q_o[IDX] = cell_r;
         end
         assign scan_out_o[c] = cell_q_o[c*CHAIN_LEN + CHAIN_LEN - 1];
      end
   endgenerate

endmodule

// File: rtl/segscan_seq.sv
module segscan_seq
   import segscan_pkg::*;
#(
   parameter int unsigned NUM_GROUPS    = 3,
   parameter int unsigned NUM_CHAINS    = 2,
   parameter int unsigned CHAIN_LEN     = 4,
   parameter int unsigned SETUP_CYCLES  = 2,
   parameter bit          EN_REGISTERED = 1'b1,
   localparam int unsigned CELLS        = NUM_CHAINS * CHAIN_LEN
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [NUM_GROUPS-1:0] hold_mask_i,
   input  logic [NUM_CHAINS-1:0] scan_in_i,
   input  logic [CELLS-1:0]      func_d_i,
   output logic [CELLS-1:0]      cell_q_o,
   output logic [NUM_CHAINS-1:0] scan_out_o,
   output logic [NUM_GROUPS-1:0] scan_en_o,
   output logic                  done_o
);

   generate
      if (NUM_GROUPS < 2) begin : g_bad_groups
         $error("segscan_seq: NUM_GROUPS must be at least 2");
      end
      if (CHAIN_LEN < 2) begin : g_bad_len
         $error("segscan_seq: CHAIN_LEN must be at least 2");
      end
      if (SETUP_CYCLES < 1) begin : g_bad_setup
         $error("segscan_seq: SETUP_CYCLES must be at least 1");
      end
      if (NUM_CHAINS < 1) begin : g_bad_chains
         $error("segscan_seq: NUM_CHAINS must be at least 1");
      end
   endgenerate

   seq_state_t            seq_state;
   logic                  cell_step;
   logic [NUM_GROUPS-1:0] hold_q;

   segscan_ctrl #(
      .NUM_GROUPS   (NUM_GROUPS),
      .CHAIN_LEN    (CHAIN_LEN),
      .SETUP_CYCLES (SETUP_CYCLES),
      .EN_REGISTERED(EN_REGISTERED)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .hold_mask_i(hold_mask_i),
      .state_o    (seq_state),
      .step_o     (cell_step),
      .scan_en_o  (scan_en_o),
      .hold_q_o   (hold_q),
      .done_o     (done_o)
   );

   segscan_cells #(
      .NUM_CHAINS(NUM_CHAINS),
      .CHAIN_LEN (CHAIN_LEN),
      .NUM_GROUPS(NUM_GROUPS)
   ) u_cells (
      .clk       (clk),
      .rst_n     (rst_n),
      .step_i    (cell_step),
      .grp_en_i  (scan_en_o),
      .scan_in_i (scan_in_i),
      .func_d_i  (func_d_i),
      .cell_q_o  (cell_q_o),
      .scan_out_o(scan_out_o)
   );

endmodule

// File: rtl/segscan_seq_chk.sv
module segscan_seq_chk
   import segscan_pkg::*;
#(
   parameter int unsigned NUM_GROUPS = 3,
   parameter int unsigned CELLS      = 8
) (
   input logic                  clk,
   input logic                  rst_n,
   input seq_state_t            state_i,
   input logic [NUM_GROUPS-1:0] hold_q_i,
   input logic [NUM_GROUPS-1:0] scan_en_i,
   input logic [CELLS-1:0]      cell_q_i,
   input logic [CELLS-1:0]      func_d_i,
   input logic                  done_i
);

   logic step_lc;
   assign step_lc = (state_i == ST_LAUNCH) || (state_i == ST_CAPTURE);

   assert_shift_all_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_SHIFT_IN || state_i == ST_SHIFT_OUT) |-> (&scan_en_i));

   assert_setup_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_SETUP) |=> (cell_q_i == $past(cell_q_i)));

   assert_launch_after_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_LAUNCH) |-> ($past(state_i) == ST_SETUP));

   assert_capture_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i == ST_LAUNCH) |=> (state_i == ST_CAPTURE));

   assert_en_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      step_lc |-> $stable(scan_en_i));

   assert_held_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (step_lc && scan_en_i[1]) |=> (cell_q_i[1] == $past(cell_q_i[0])));

   assert_free_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_lc && !scan_en_i[1]) |=> (cell_q_i[1] == $past(func_d_i[1])));

   assert_mask_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_i != ST_IDLE && $past(state_i) != ST_IDLE) |-> $stable(hold_q_i));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> !done_i);

endmodule

bind segscan_seq segscan_seq_chk #(
   .NUM_GROUPS(NUM_GROUPS),
   .CELLS     (CELLS)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .state_i  (seq_state),
   .hold_q_i (hold_q),
   .scan_en_i(scan_en_o),
   .cell_q_i (cell_q_o),
   .func_d_i (func_d_i),
   .done_i   (done_o)
);

// File: tb/test_segscan_seq.sv
module test_segscan_seq;

   localparam int NG = 3;
   localparam int NC = 2;
   localparam int L  = 4;
   localparam int S  = 2;
   localparam int C  = NC * L;
   localparam int CLK_PERIOD = 10;
   localparam int WATCHDOG   = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [NG-1:0] hold_mask_i = '0;
   logic [NC-1:0] scan_in_i = '0;
   logic [C-1:0]  func_d_i;
   logic [C-1:0]  cell_q_o;
   logic [NC-1:0] scan_out_o;
   logic [NG-1:0] scan_en_o;
   logic          done_o;

   int n_tests = 0;
   int n_fail  = 0;
   logic [C-1:0] resid = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   // Stand-in logic cloud of the circuit under test.
   function automatic logic [C-1:0] cloud(input logic [C-1:0] st);
      logic [C-1:0] r;
      for (int i = 0; i < C; i++)
         r[i] = st[(i+1)%C] ^ ~(st[(i+3)%C] & st[(i+6)%C]);
      return r;
   endfunction

   assign func_d_i = cloud(cell_q_o);

   function automatic logic [C-1:0] model_step(input logic [C-1:0] st,
                                               input logic [NG-1:0] mask,
                                               input logic [NC-1:0] si);
      logic [C-1:0] f;
      logic [C-1:0] r;
      f = cloud(st);
      for (int i = 0; i < C; i++) begin
         int c;
         int p;
         c = i / L;
         p = i % L;
         if (mask[p % NG]) r[i] = (p == 0) ? si[c] : st[i-1];
         else              r[i] = f[i];
      end
      return r;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_test(input logic [NG-1:0] mask, input logic [C-1:0] vec,
                           input logic [NC-1:0] si_lc, input logic [C-1:0] fill);
      logic [C-1:0]  resp;
      logic [C-1:0]  got_out;
      logic [C-1:0]  got_ovl;
      bit            en_ok;
      bit            done_ok;
      bit            hold_ok;
      logic [NG-1:0] bad_en;
      resp    = model_step(model_step(vec, mask, si_lc), mask, si_lc);
      got_out = '0;
      got_ovl = '0;
      en_ok   = 1'b1;
      done_ok = 1'b1;
      hold_ok = 1'b1;
      bad_en  = '0;
      @(negedge clk);
      start_i     = 1'b1;
      hold_mask_i = mask;
      @(posedge clk);
      for (int n = 0; n <= 2*L + S + 3; n++) begin
         logic [NG-1:0] exp_en;
         @(negedge clk);
         // R8: disturb mask and strobe start in mid-test
         if (n == 0) start_i = 1'b0;
         if (n == 2) begin
            start_i     = 1'b1;
            hold_mask_i = ~mask;
         end
         if (n == 3) start_i = 1'b0;
         exp_en = (n >= L && n <= L + S + 1) ? mask : '1;
         if (n <= 2*L + S + 2 && scan_en_o !== exp_en) begin
            en_ok  = 1'b0;
            bad_en = scan_en_o;
         end
         if (done_o !== (n == 2*L + S + 2)) done_ok = 1'b0;
         if (n < L) begin
            for (int c = 0; c < NC; c++) begin
               got_ovl[c*L + L-1-n] = scan_out_o[c];
               scan_in_i[c]         = vec[c*L + L-1-n];
            end
         end else if (n < L + S) begin
            if (cell_q_o !== vec) hold_ok = 1'b0;
            scan_in_i = si_lc;
         end else if (n < L + S + 2) begin
            scan_in_i = si_lc;
         end else if (n < 2*L + S + 2) begin
            for (int c = 0; c < NC; c++) begin
               int k;
               k = n - (L + S + 2);
               got_out[c*L + L-1-k] = scan_out_o[c];
               scan_in_i[c]         = fill[c*L + L-1-k];
            end
         end else begin
            scan_in_i = '0;
         end
      end
      hold_mask_i = '0;
      check(en_ok, "R2 R3 R4 R8 R11 enables", 64'(bad_en), 64'(mask));
      check(hold_ok, "R3 settle hold", 64'(cell_q_o), 64'(vec));
      check(got_ovl === resid, "R9 overlap unload", 64'(got_ovl), 64'(resid));
      if (mask == '0)
         check(got_out === resp, "R7 broadside response", 64'(got_out), 64'(resp));
      else
         check(got_out === resp, "R5 R6 R10 R11 mixed response", 64'(got_out), 64'(resp));
      check(done_ok, "R10 done pulse", 64'(done_o), 64'(0));
      resid = fill;
   endtask

   task automatic finish_up();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   segscan_seq #(
      .NUM_GROUPS  (NG),
      .NUM_CHAINS  (NC),
      .CHAIN_LEN   (L),
      .SETUP_CYCLES(S)
   ) i_segscan_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (start_i),
      .hold_mask_i(hold_mask_i),
      .scan_in_i  (scan_in_i),
      .func_d_i   (func_d_i),
      .cell_q_o   (cell_q_o),
      .scan_out_o (scan_out_o),
      .scan_en_o  (scan_en_o),
      .done_o     (done_o)
   );

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_up();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check(scan_en_o === '1, "R1 reset enables", 64'(scan_en_o), 64'('1));
      check(done_o === 1'b0, "R1 reset done", 64'(done_o), 64'(0));
      check(cell_q_o === '0, "R1 reset cells", 64'(cell_q_o), 64'(0));
      rst_n = 1'b1;
      @(negedge clk);
      check(scan_en_o === '1 && scan_out_o === '0, "R1 after reset", 64'(scan_en_o), 64'('1));
      // R11 group mapping and R5/R6/R7 response over every mask
      for (int m = 0; m < (1 << NG); m++) begin
         for (int v = 0; v < 3; v++) begin
            logic [C-1:0]  vec;
            logic [C-1:0]  fill;
            logic [NC-1:0] si;
            vec  = C'(8'hA5 ^ (m * 8'h1D) ^ (v * 8'h6B));
            fill = C'(8'h3C + m * 8'h11 + v * 8'h47);
            si   = NC'(m + v);
            run_test(NG'(m), vec, si, fill);
            repeat (v) @(negedge clk);
         end
      end
      finish_up();
   end

endmodule